// File: doc/BRIEF.md
# Gamma Register Auto-Load Sequencer

This block refills the two banks of gamma channel registers from an external serial EEPROM without any host involvement. A restart can come from three sources: reset, a general-call reset pulse, or a read-again pulse. After a restart the sequencer counts five pulses of a 1 ms tick and then asks a separate two-wire bus master primitive for the first byte. If the EEPROM does not answer, the sequencer waits one more tick and asks again. It gives up after ten attempts. Once the EEPROM answers, the sequencer streams 48 bytes, 24 per bank and two per channel, and writes each one into the register file as it arrives. It then pulses a strobe that moves every register to its output at the same time.

Two select inputs set the layout of the EEPROM. One chooses which address window holds the two banks. The other chooses between a two-byte word address and a one-byte word address with extra block bits. An enable input can cancel the sequence at any point before the final strobe. While the sequence runs, a busy flag stays high so that the slave interface can refuse accesses.

Top module: `gl_autoload_seq`

## Requirements
- R1: After reset, `busy` is 1 and `rd_req`, `wr_en` and `load_all` are 0. No request is made during the first four tick pulses. `rd_req` goes high in the cycle after the clock edge that samples the fifth tick pulse.
- R2: Address windows (`size_sel[1]` picks the window):
  - With `size_sel[1]`=0, bank 0 is read from addresses 0..23 and bank 1 from 24..47.
  - With `size_sel[1]`=1, bank 0 is read from 361..384 and bank 1 from 405..428.
  - Bytes are requested in ascending order, all of bank 0 first.
- R3: Address encoding (`size_sel[0]` picks the mode):
  - With `size_sel[0]`=1, `rd_wide`=1, `rd_word` carries the full address and `rd_blk`=0.
  - With `size_sel[0]`=0, `rd_wide`=0, `rd_word`={8'h00, address[7:0]} and `rd_blk`=address[10:8].
- R4: Each byte delivered with `rd_ack` produces one write in the next cycle.
  - Byte k of a bank (k=0..23) goes to channel k/2 of that bank. Even k is the high byte (`wr_msb`=1) and keeps only data bits 1:0, with bits 7:2 forced to 0. Odd k is the low byte and is written unchanged.
- R5: A `rd_nack` drops `rd_req` in the next cycle. The request is made again, for the first byte of bank 0, in the cycle after the next tick pulse.
- R6: After the tenth attempt is refused, `busy` falls. No further request is made and `load_all` is not pulsed.
- R7: If `enable` is 0 during the wait, `busy` falls one cycle later and no request is made.
- R8: If `enable` goes to 0 during the download, `busy` falls one cycle later. No more writes follow and `load_all` is not pulsed.
- R9: After the 48th byte, `load_all` pulses for one cycle, one cycle after the final write. `busy` falls in that same cycle.
- R10: A one-cycle `gcall_reset` or `read_again` pulse restarts the whole sequence, including the five-tick wait and the attempt count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (acts as power-on restart) |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| gcall_reset | input | 1 | Restart pulse from a general-call reset |
| read_again | input | 1 | Restart pulse from a read-again command |
| enable | input | 1 | Auto-load enable; low cancels or skips the load |
| size_sel | input | 2 | Bit 1: address window; bit 0: two-byte word address |
| rd_ack | input | 1 | Byte delivered by the bus master, data on rd_data |
| rd_nack | input | 1 | EEPROM did not acknowledge the request |
| rd_data | input | 8 | Byte read from the EEPROM |
| busy | output | 1 | High from restart until slave mode is entered |
| rd_req | output | 1 | Byte-read request, held until rd_ack or rd_nack |
| rd_word | output | 16 | Word address for the request |
| rd_blk | output | 3 | Block bits for the device-select byte in one-byte mode |
| rd_wide | output | 1 | Request uses a two-byte word address |
| wr_en | output | 1 | Register write strobe |
| wr_bank | output | 1 | Target bank of the write |
| wr_chan | output | 4 | Target channel of the write |
| wr_msb | output | 1 | Write carries data bits 9:8 (high byte) |
| wr_byte | output | 8 | Write data |
| load_all | output | 1 | One-cycle pulse moving all registers to the outputs |

## Verification
The bench drives inputs and samples outputs on the falling clock edge.

Timing of the registered results:
- A request appears one rising edge after the fifth sampled tick. A retry appears one rising edge after the first tick that follows a refusal.
- Each register write appears one edge after its acknowledge.
- The load strobe and the fall of `busy` come together one edge after the final write.

The bus responder answers at the falling edge after it sees a request. At that moment it also pushes the write it expects into a queue. The monitor pops that entry when the write shows up one cycle later, so a write that is late, early, extra or missing is caught by the pop or by a queue that is not empty at the end. Cancel and refusal cases are checked at the falling edge that directly follows the cause.

// File: rtl/gl_pkg.sv
package gl_pkg;

    localparam int ADDR_W = 16;

    // Start addresses of the two bank windows.
    localparam logic [ADDR_W-1:0] LOWWIN_BANK0  = 16'd0;
    localparam logic [ADDR_W-1:0] LOWWIN_BANK1  = 16'd24;
    localparam logic [ADDR_W-1:0] HIGHWIN_BANK0 = 16'd361;
    localparam logic [ADDR_W-1:0] HIGHWIN_BANK1 = 16'd405;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_ISSUE,
        ST_RETRY,
        ST_FINISH,
        ST_SLAVE
    } load_state_e;

    typedef struct packed {
        logic       bank;
        logic [3:0] chan;
        logic       msb;
        logic [7:0] data;
    } wr_item_t;

    function automatic logic [ADDR_W-1:0] window_base(input logic upper_win, input logic bank);
        if (upper_win) return bank ? HIGHWIN_BANK1 : HIGHWIN_BANK0;
        return bank ? LOWWIN_BANK1 : LOWWIN_BANK0;
    endfunction

endpackage

// File: rtl/gl_ms_timer.sv
module gl_ms_timer #(
    parameter int MAX_MS = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run,
    input  logic                         tick,
    input  logic [$clog2(MAX_MS+1)-1:0]  limit,
    output logic                         done
);
    localparam int CW = $clog2(MAX_MS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= cnt + CW'(1);
    end

    assign done = run && tick && (cnt == limit - CW'(1));

endmodule

// File: rtl/gl_addr_map.sv
module gl_addr_map #(
    parameter int IDX_W = 5
) (
    input  logic [1:0]              size_sel,
    input  logic                    bank,
    input  logic [IDX_W-1:0]        idx,
    output logic [gl_pkg::ADDR_W-1:0] full_addr,
    output logic [15:0]             word,
    output logic [2:0]              blk,
    output logic                    wide
);
    import gl_pkg::*;

    assign full_addr = window_base(size_sel[1], bank) + ADDR_W'(idx);
    assign wide      = size_sel[0];

    generate
        if (ADDR_W >= 11) begin : g_blk
            always_comb begin
                if (wide) begin
                    word = full_addr[15:0];
                    blk  = 3'd0;
                end else begin
                    word = {8'h00, full_addr[7:0]};
                    blk  = full_addr[10:8];
                end
            end
        end else begin : g_noblk
            always_comb begin
                word = 16'(full_addr);
                blk  = 3'd0;
            end
        end
    endgenerate

endmodule

// File: rtl/gl_wr_fmt.sv
module gl_wr_fmt #(
    parameter int IDX_W        = 5,
    parameter int BYTES_PER_CH = 2
) (
    input  logic             bank,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    output gl_pkg::wr_item_t item
);
    localparam int HI_KEEP = 2;

    logic msb;
    assign msb = (idx % IDX_W'(BYTES_PER_CH)) == '0;

    always_comb begin
        item.bank = bank;
        item.chan = 4'(idx / IDX_W'(BYTES_PER_CH));
        item.msb  = msb;
        item.data = msb ? {{(8-HI_KEEP){1'b0}}, data[HI_KEEP-1:0]} : data;
    end

endmodule

// File: rtl/gl_autoload_seq.sv
module gl_autoload_seq #(
    parameter int START_WAIT_MS = 5,
    parameter int RETRY_MS      = 1,
    parameter int MAX_TRIES     = 10,
    parameter int CHANNELS      = 12,
    parameter int BYTES_PER_CH  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_1ms,
    input  logic        gcall_reset,
    input  logic        read_again,
    input  logic        enable,
    input  logic [1:0]  size_sel,
    input  logic        rd_ack,
    input  logic        rd_nack,
    input  logic [7:0]  rd_data,
    output logic        busy,
    output logic        rd_req,
    output logic [15:0] rd_word,
    output logic [2:0]  rd_blk,
    output logic        rd_wide,
    output logic        wr_en,
    output logic        wr_bank,
    output logic [3:0]  wr_chan,
    output logic        wr_msb,
    output logic [7:0]  wr_byte,
    output logic        load_all
);
    import gl_pkg::*;

    localparam int BANK_BYTES = CHANNELS * BYTES_PER_CH;
    localparam int IDX_W      = $clog2(BANK_BYTES);
    localparam int TRY_W      = $clog2(MAX_TRIES + 1);
    localparam int TMR_MAX    = START_WAIT_MS + RETRY_MS;
    localparam int TMR_W      = $clog2(TMR_MAX + 1);

    load_state_e        state;
    logic [TRY_W-1:0]   tries;
    logic [IDX_W-1:0]   idx;
    logic               bank;
    logic               restart;
    logic               tmr_run;
    logic               tmr_done;
    logic [TMR_W-1:0]   tmr_limit;
    logic [ADDR_W-1:0]  full_addr;
    wr_item_t           fmt_item;
    wr_item_t           wr_q;
    logic               last_idx;

    assign restart   = gcall_reset || read_again;
    assign tmr_run   = (state == ST_WAIT) || (state == ST_RETRY);
    assign tmr_limit = (state == ST_WAIT) ? TMR_W'(START_WAIT_MS) : TMR_W'(RETRY_MS);
    assign last_idx  = (idx == IDX_W'(BANK_BYTES - 1));

    gl_ms_timer #(.MAX_MS(TMR_MAX)) u_timer (
        .clk   (clk),
        .rst   (rst || restart),
        .run   (tmr_run),
        .tick  (tick_1ms),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    gl_addr_map #(.IDX_W(IDX_W)) u_map (
        .size_sel  (size_sel),
        .bank      (bank),
        .idx       (idx),
        .full_addr (full_addr),
        .word      (rd_word),
        .blk       (rd_blk),
        .wide      (rd_wide)
    );

    gl_wr_fmt #(.IDX_W(IDX_W), .BYTES_PER_CH(BYTES_PER_CH)) u_fmt (
        .bank (bank),
        .idx  (idx),
        .data (rd_data),
        .item (fmt_item)
    );

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state    <= ST_WAIT;
            tries    <= '0;
            idx      <= '0;
            bank     <= 1'b0;
            wr_en    <= 1'b0;
            wr_q     <= '0;
            load_all <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            load_all <= 1'b0;
            unique case (state)
                ST_WAIT, ST_RETRY: begin
                    if (!enable) begin
                        state <= ST_SLAVE;
                    end else if (tmr_done) begin
                        state <= ST_ISSUE;
                        tries <= tries + TRY_W'(1);
                        idx   <= '0;
                        bank  <= 1'b0;
                    end
                end
                ST_ISSUE: begin
                    if (!enable) begin
                        state <= ST_SLAVE;
                    end else if (rd_nack) begin
                        state <= (tries == TRY_W'(MAX_TRIES)) ? ST_SLAVE : ST_RETRY;
                    end else if (rd_ack) begin
                        wr_en <= 1'b1;
                        wr_q  <= fmt_item;
                        if (last_idx && bank) begin
                            state <= ST_FINISH;
                        end else if (last_idx) begin
                            bank <= 1'b1;
                            idx  <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                ST_FINISH: begin
                    load_all <= 1'b1;
                    state    <= ST_SLAVE;
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state != ST_SLAVE);
    assign rd_req  = (state == ST_ISSUE);
    assign wr_bank = wr_q.bank;
    assign wr_chan = wr_q.chan;
    assign wr_msb  = wr_q.msb;
    assign wr_byte = wr_q.data;

    // R1: nothing is requested or written once slave mode is entered
    a_r1_quiet_in_slave: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_req && !wr_en);

    // R2: every request lies inside the selected window pair
    a_r2_window: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (size_sel[1] ? (full_addr >= 16'd361 && full_addr <= 16'd428)
                                : (full_addr <= 16'd47)));

    // R4: a high byte never carries bits above data bit 9
    a_r4_msb_mask: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_msb |-> wr_byte[7:2] == 6'd0);

    // R5: an unanswered request holds its address
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ack && !rd_nack && enable && !restart
        |=> rd_req && $stable(rd_word) && $stable(rd_blk));

    // R6: the attempt count never exceeds its bound
    a_r6_try_bound: assert property (@(posedge clk) disable iff (rst)
        tries <= TRY_W'(MAX_TRIES));

    // R7, R8: enable low ends the sequence one cycle later
    a_r8_enable_abort: assert property (@(posedge clk) disable iff (rst)
        !enable && !restart && (state != ST_FINISH) |=> !busy);

    // R9: the load strobe follows the final write and ends busy
    a_r9_load_after_write: assert property (@(posedge clk) disable iff (rst)
        load_all |-> !busy && $past(wr_en));

endmodule

// File: tb/test_gl_autoload_seq.sv
module test_gl_autoload_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1ms = 1'b0;
    logic        gcall_reset = 1'b0;
    logic        read_again = 1'b0;
    logic        enable = 1'b1;
    logic [1:0]  size_sel = 2'b00;
    logic        rd_ack = 1'b0;
    logic        rd_nack = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        busy, rd_req, rd_wide, wr_en, wr_bank, wr_msb, load_all;
    logic [15:0] rd_word;
    logic [2:0]  rd_blk;
    logic [3:0]  wr_chan;
    logic [7:0]  wr_byte;

    always #(CLK_PERIOD/2) clk = ~clk;

    gl_autoload_seq i_gl_autoload_seq (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .gcall_reset(gcall_reset),
        .read_again(read_again), .enable(enable), .size_sel(size_sel),
        .rd_ack(rd_ack), .rd_nack(rd_nack), .rd_data(rd_data),
        .busy(busy), .rd_req(rd_req), .rd_word(rd_word), .rd_blk(rd_blk),
        .rd_wide(rd_wide), .wr_en(wr_en), .wr_bank(wr_bank), .wr_chan(wr_chan),
        .wr_msb(wr_msb), .wr_byte(wr_byte), .load_all(load_all)
    );

    int total = 0;
    int bad = 0;
    int ack_cnt = 0;
    int nack_cnt = 0;
    int nack_left = 0;
    int load_cnt = 0;
    int exp_idx = 0;
    int cycles = 0;
    bit resp_on = 1'b0;
    bit prev_wr = 1'b0;
    logic [13:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int base_of(input bit upper, input bit bnk);
        if (upper) return bnk ? 405 : 361;
        return bnk ? 24 : 0;
    endfunction

    // Responder: models the bus master, pushes the expected write on every ack
    always @(negedge clk) begin
        if (rd_ack || rd_nack) begin
            rd_ack  = 1'b0;
            rd_nack = 1'b0;
        end else if (resp_on && rd_req) begin
            bit bnk;
            int k, full, decoded;
            logic [7:0] d;
            bnk = (exp_idx >= 24);
            k = exp_idx % 24;
            full = base_of(size_sel[1], bnk) + k;
            decoded = size_sel[0] ? int'(rd_word) : int'({rd_blk, rd_word[7:0]});
            chk(decoded == full, "R2 address", decoded, full);
            if (size_sel[0])
                chk(rd_wide && rd_blk == 3'd0 && rd_word == 16'(full), "R3 wide form",
                    int'(rd_word), full);
            else
                chk(!rd_wide && rd_word[15:8] == 8'd0 && rd_blk == 3'(full >> 8), "R3 narrow form",
                    int'({rd_blk, rd_word}), full);
            if (nack_left > 0) begin
                nack_left--;
                nack_cnt++;
                exp_idx = 0;
                rd_nack = 1'b1;
            end else begin
                d = 8'(full) ^ 8'hA5 ^ 8'(full >> 8);
                rd_data = d;
                rd_ack = 1'b1;
                ack_cnt++;
                exp_q.push_back({bnk, 4'(k / 2), (k % 2) == 0,
                                 ((k % 2) == 0) ? {6'd0, d[1:0]} : d});
                exp_idx++;
            end
        end
    end

    // Monitor: pops expected writes, checks the load strobe
    always @(negedge clk) begin
        cycles++;
        if (wr_en) begin
            logic [13:0] got;
            logic [13:0] exp;
            got = {wr_bank, wr_chan, wr_msb, wr_byte};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected write", int'(got), -1);
            end else begin
                exp = exp_q.pop_front();
                chk(got == exp, "R4 write content", int'(got), int'(exp));
            end
        end
        if (load_all) begin
            load_cnt++;
            chk(prev_wr && !busy, "R9 load after final write", int'({prev_wr, busy}), 2);
        end
        prev_wr = wr_en;
    end

    task automatic tick1();
        @(negedge clk) tick_1ms = 1'b1;
        @(negedge clk) tick_1ms = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_wait(input string req);
        repeat (4) tick1();
        chk(busy && !rd_req, req, int'({busy, rd_req}), 2);
        @(negedge clk) tick_1ms = 1'b1;
        @(negedge clk) tick_1ms = 1'b0;
        chk(rd_req, req, int'(rd_req), 1);
    endtask

    task automatic run_idle();
        int g = 0;
        while (busy && g < 400) begin
            tick1();
            g++;
        end
    endtask

    task automatic pulse(input bit ra);
        exp_idx = 0;
        @(negedge clk);
        if (ra) read_again = 1'b1; else gcall_reset = 1'b1;
        @(negedge clk);
        read_again = 1'b0;
        gcall_reset = 1'b0;
    endtask

    task automatic do_reset();
        exp_idx = 0;
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int acks0;
        // Case 1: power-on, low window, one-byte addressing
        resp_on = 1'b1;
        size_sel = 2'b00;
        do_reset();
        chk(busy && !rd_req && !wr_en && !load_all, "R1 reset state",
            int'({busy, rd_req, wr_en, load_all}), 8);
        start_wait("R1 five-tick wait");
        run_idle();
        chk(load_cnt == 1, "R9 load count", load_cnt, 1);
        chk(ack_cnt == 48, "R4 byte count", ack_cnt, 48);
        chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);

        // Case 2: read-again, high window, narrow, three refusals
        size_sel = 2'b01;
        nack_left = 3;
        pulse(1'b1);
        chk(busy && !rd_req, "R10 read-again restart", int'({busy, rd_req}), 2);
        start_wait("R10 wait after read-again");
        wait (nack_cnt == 1);
        @(negedge clk);
        chk(!rd_req && busy, "R5 request drops after refusal", int'({busy, rd_req}), 2);
        run_idle();
        chk(nack_cnt == 3, "R5 refusals taken", nack_cnt, 3);
        chk(load_cnt == 2, "R9 load after retries", load_cnt, 2);
        chk(exp_q.size() == 0, "R4 writes after retries", exp_q.size(), 0);

        // Case 3: general call, high window, two-byte addressing
        size_sel = 2'b11;
        pulse(1'b0);
        chk(busy && !rd_req, "R10 general-call restart", int'({busy, rd_req}), 2);
        start_wait("R10 wait after general call");
        run_idle();
        chk(load_cnt == 3, "R9 load wide mode", load_cnt, 3);
        chk(ack_cnt == 144, "R3 bytes wide mode", ack_cnt, 144);

        // Case 4: ten refusals
        size_sel = 2'b10;
        nack_cnt = 0;
        nack_left = 1000;
        pulse(1'b1);
        start_wait("R10 wait before refusals");
        repeat (12) tick1();
        chk(!busy, "R6 gives up", int'(busy), 0);
        chk(nack_cnt == 10, "R6 attempt count", nack_cnt, 10);
        chk(load_cnt == 3, "R6 no load", load_cnt, 3);
        nack_left = 0;

        // Case 5: enable low at power-on
        enable = 1'b0;
        do_reset();
        @(negedge clk);
        chk(!busy, "R7 enable low skips load", int'(busy), 0);
        acks0 = ack_cnt;
        repeat (7) tick1();
        chk(!rd_req && ack_cnt == acks0 && load_cnt == 3, "R7 no request",
            ack_cnt - acks0, 0);

        // Case 6: enable dropped mid-download
        enable = 1'b1;
        size_sel = 2'b00;
        do_reset();
        start_wait("R1 wait before abort");
        acks0 = ack_cnt;
        wait (ack_cnt == acks0 + 10);
        resp_on = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy, "R8 still busy before abort", int'(busy), 1);
        enable = 1'b0;
        @(negedge clk);
        chk(!busy, "R8 abort ends busy", int'(busy), 0);
        resp_on = 1'b1;
        repeat (4) tick1();
        chk(load_cnt == 3, "R8 no load after abort", load_cnt, 3);
        chk(exp_q.size() == 0 && ack_cnt == acks0 + 10, "R8 no further writes",
            ack_cnt - acks0, 10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        chk(1'b0, "watchdog", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule